// File: doc/BRIEF.md
# SPI master serial clock generator

This block makes the serial clock for an SPI master. The system clock first passes through a power-of-two prescaler. Two programmable counts then set how long the serial clock stays low and how long it stays high, so that one setting fixes both the frequency and the duty cycle. A polarity input sets the level the clock rests at. A phase input decides whether data is sampled on the edge that leaves the rest level or on the edge that returns to it.

A sequencer holds `run_i` high for as long as characters are to be clocked. On each edge the block raises a one-cycle strobe for the shifter: `sample_o` on capture edges and `launch_o` on drive edges. It counts edges against the configured character length and pulses `char_done_o` together with the final sample strobe of each character. The configuration inputs are expected to stay stable while the clock runs.

The controller has three states. `S_IDLE` holds the clock at its rest level. `S_REST` times the phase at the rest level. `S_DRIVE` times the phase at the opposite level. The transitions are:
- IDLE→REST when `run_i` is high.
- REST→DRIVE when the rest phase expires, which is the leading edge.
- DRIVE→REST when the drive phase expires and either the character is not finished or `run_i` is still high, which is a trailing edge.
- DRIVE→IDLE when the final trailing edge of a character occurs with `run_i` low.

Top module: `sclk_gen`

## Requirements
- R1: While `rst_n` is low, `sclk_o`, `sample_o`, `launch_o` and `char_done_o` are all 0.
- R2: Between bursts, `sclk_o` equals `cpol_i` and no strobe or done pulse is raised.
- R3: The serial clock stays low for max(`lo_cnt_i`,1)·2^`scale_i` system clock cycles.
- R4: The serial clock stays high for max(`hi_cnt_i`,1)·2^`scale_i` system clock cycles.
- R5: A high or low count of 0 lasts exactly one prescaled tick, so the clock never stalls.
- R6: With `cpol_i`=0 the clock rests low; with `cpol_i`=1 it rests high, and the leading edge is falling.
- R7: With `cpha_i`=0, `sample_o` pulses on every leading edge (the edge leaving the rest level) and `launch_o` pulses on every trailing edge.
- R8: With `cpha_i`=1, `sample_o` pulses on every trailing edge and `launch_o` pulses on every leading edge.
- R9: A character is `char_bits_i` bits long, with 0 meaning 16 bits. It spans twice that many edges. `char_done_o` pulses in the same cycle as its last `sample_o`.
- R10: While `run_i` stays high, characters follow one another with no gap. If `run_i` is low at a character's final trailing edge, the clock returns to rest and stops. The first edge comes one rest phase after the cycle that registers `run_i`.
- R11: Each strobe lasts one cycle. The two strobes never coincide, and a strobe appears only in the cycle where `sclk_o` shows its new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Run request from the sequencer |
| scale_i | input | 4 | Prescaler exponent, divide by 2^scale_i |
| lo_cnt_i | input | 8 | Low-phase length in prescaled ticks (0 acts as 1) |
| hi_cnt_i | input | 8 | High-phase length in prescaled ticks (0 acts as 1) |
| cpol_i | input | 1 | Rest level of the serial clock |
| cpha_i | input | 1 | 0: sample on leading edges, 1: sample on trailing edges |
| char_bits_i | input | 4 | Bits per character, 0 means 16 |
| sclk_o | output | 1 | Serial clock |
| sample_o | output | 1 | One-cycle capture strobe |
| launch_o | output | 1 | One-cycle drive strobe |
| char_done_o | output | 1 | Pulse with the last sample strobe of a character |

## Verification
All outputs are registered. The first clock change appears rest-phase-length plus one cycles after `run_i` is presented, and each later change appears exactly one phase length after the previous one. Strobes and the done pulse are due in the very cycle the clock shows its new level. The bench samples on falling edges, counts the cycles between observed level changes, and checks the strobes in the cycle of each change. It also requires quiet outputs in every cycle between changes and over a long window after each burst.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_REST  = 2'd1,
        S_DRIVE = 2'd2
    } sclk_state_e;
endpackage

// File: rtl/sclk_prescale.sv
// Tick generator: one tick every 2^scale cycles while enabled.
module sclk_prescale #(
    parameter int SCALE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [SCALE_W-1:0] scale,
    output logic               tick
);
    localparam int CNT_W = (1 << SCALE_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   lim_w;

    assign lim_w = ((CNT_W+1)'(1) << scale) - (CNT_W+1)'(1);
    assign tick  = en && (cnt_q == lim_w[CNT_W-1:0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!en || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/sclk_phase_timer.sv
// Counts prescaled ticks within one clock phase; zero length acts as one.
module sclk_phase_timer #(
    parameter int PHASE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               tick,
    input  logic [PHASE_W-1:0] len,
    output logic               done
);
    logic [PHASE_W-1:0] cnt_q;
    logic [PHASE_W-1:0] len_eff;

    assign len_eff = (len == '0) ? PHASE_W'(1) : len;
    assign done    = tick && (cnt_q == len_eff - PHASE_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!en || done)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + PHASE_W'(1);
    end
endmodule

// File: rtl/sclk_edge_count.sv
// Tracks the edge index within a character and classifies the next edge.
module sclk_edge_count #(
    parameter int BITS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              edge_i,
    input  logic              cpha,
    input  logic [BITS_W-1:0] bits,
    output logic              samp_sel,
    output logic              last_samp,
    output logic              last_edge
);
    localparam int NB_W     = BITS_W + 1;
    localparam int EDGE_W   = BITS_W + 2;
    localparam int MAX_BITS = 1 << BITS_W;

    logic [EDGE_W-1:0] cnt_q;
    logic [NB_W-1:0]   n_bits;
    logic [EDGE_W-1:0] last_idx;
    logic              is_lead;

    assign n_bits    = (bits == '0) ? NB_W'(MAX_BITS) : NB_W'(bits);
    assign last_idx  = {n_bits, 1'b0} - EDGE_W'(1);
    assign is_lead   = ~cnt_q[0];
    assign samp_sel  = cpha ? ~is_lead : is_lead;
    assign last_edge = (cnt_q == last_idx);
    assign last_samp = cpha ? last_edge : (cnt_q == last_idx - EDGE_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!en)
            cnt_q <= '0;
        else if (edge_i)
            cnt_q <= last_edge ? '0 : cnt_q + EDGE_W'(1);
    end
endmodule

// File: rtl/sclk_gen.sv
// SPI master serial clock generator: prescaler, phase timing, edge strobes.
module sclk_gen
    import sclk_pkg::*;
#(
    parameter int SCALE_W = 4,
    parameter int PHASE_W = 8,
    parameter int BITS_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic [SCALE_W-1:0] scale_i,
    input  logic [PHASE_W-1:0] lo_cnt_i,
    input  logic [PHASE_W-1:0] hi_cnt_i,
    input  logic               cpol_i,
    input  logic               cpha_i,
    input  logic [BITS_W-1:0]  char_bits_i,
    output logic               sclk_o,
    output logic               sample_o,
    output logic               launch_o,
    output logic               char_done_o
);
    sclk_state_e        state_q, state_n;
    logic               active;
    logic               tick;
    logic               edge_w;
    logic               lvl_now;
    logic [PHASE_W-1:0] phase_len;
    logic               samp_sel, last_samp, last_edge;

    assign active    = (state_q != S_IDLE);
    assign lvl_now   = (state_q == S_DRIVE) ^ cpol_i;
    assign phase_len = lvl_now ? hi_cnt_i : lo_cnt_i;

    sclk_prescale #(.SCALE_W(SCALE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (active),
        .scale (scale_i),
        .tick  (tick)
    );

    sclk_phase_timer #(.PHASE_W(PHASE_W)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (active),
        .tick  (tick),
        .len   (phase_len),
        .done  (edge_w)
    );

    sclk_edge_count #(.BITS_W(BITS_W)) u_edges (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (active),
        .edge_i    (edge_w),
        .cpha      (cpha_i),
        .bits      (char_bits_i),
        .samp_sel  (samp_sel),
        .last_samp (last_samp),
        .last_edge (last_edge)
    );

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            S_IDLE:  if (run_i) state_n = S_REST;
            S_REST:  if (edge_w) state_n = S_DRIVE;
            S_DRIVE: if (edge_w) state_n = (last_edge && !run_i) ? S_IDLE : S_REST;
            default: state_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_o      <= 1'b0;
            sample_o    <= 1'b0;
            launch_o    <= 1'b0;
            char_done_o <= 1'b0;
        end else begin
            sclk_o      <= (state_n == S_DRIVE) ^ cpol_i;
            sample_o    <= edge_w && samp_sel;
            launch_o    <= edge_w && !samp_sel;
            char_done_o <= edge_w && samp_sel && last_samp;
        end
    end
endmodule

// File: rtl/sclk_gen_chk.sv
module sclk_gen_chk
    import sclk_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        run_i,
    input logic        cpol_i,
    input logic        sclk_o,
    input logic        sample_o,
    input logic        launch_o,
    input logic        char_done_o,
    input sclk_state_e state_q
);
    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    p_idle_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && state_q == S_IDLE && $past(state_q) == S_IDLE) |-> sclk_o == $past(cpol_i));

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && state_q == S_IDLE && $past(state_q) == S_IDLE)
            |-> (!sample_o && !launch_o && !char_done_o));

    p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_o && launch_o));

    p_strobe_toggle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_o || launch_o) |-> sclk_o != $past(sclk_o));

    p_done_sample_r9: assert property (@(posedge clk) disable iff (!rst_n)
        char_done_o |-> sample_o);

    p_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && run_i) |=> state_q == S_REST);
endmodule

bind sclk_gen sclk_gen_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_i       (run_i),
    .cpol_i      (cpol_i),
    .sclk_o      (sclk_o),
    .sample_o    (sample_o),
    .launch_o    (launch_o),
    .char_done_o (char_done_o),
    .state_q     (state_q)
);

// File: tb/test_sclk_gen.sv
`timescale 1ns/1ps
module test_sclk_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_i = 1'b0;
    logic [3:0] scale_i = '0;
    logic [7:0] lo_cnt_i = '0;
    logic [7:0] hi_cnt_i = '0;
    logic       cpol_i = 1'b0;
    logic       cpha_i = 1'b0;
    logic [3:0] char_bits_i = '0;
    logic       sclk_o, sample_o, launch_o, char_done_o;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    sclk_gen i_sclk_gen (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .scale_i(scale_i),
        .lo_cnt_i(lo_cnt_i), .hi_cnt_i(hi_cnt_i), .cpol_i(cpol_i),
        .cpha_i(cpha_i), .char_bits_i(char_bits_i), .sclk_o(sclk_o),
        .sample_o(sample_o), .launch_o(launch_o), .char_done_o(char_done_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int phase_cycles(input bit level);
        int f = level ? int'(hi_cnt_i) : int'(lo_cnt_i);
        if (f == 0) f = 1;
        return f << scale_i;
    endfunction

    function automatic int char_len();
        return (char_bits_i == 0) ? 16 : int'(char_bits_i);
    endfunction

    task automatic configure(input int sc, input int lo, input int hi,
                             input bit pol, input bit pha, input int nb);
        @(negedge clk);
        scale_i = 4'(sc); lo_cnt_i = 8'(lo); hi_cnt_i = 8'(hi);
        cpol_i = pol; cpha_i = pha; char_bits_i = 4'(nb);
        repeat (3) @(negedge clk);
        check(sclk_o == pol, "R6 rest level", int'(sclk_o), int'(pol));
        check(!sample_o && !launch_o && !char_done_o, "R2 quiet idle",
              int'({sample_o, launch_o, char_done_o}), 0);
    endtask

    task automatic burst(input int nch);
        int  n     = char_len();
        int  total = 2 * n * nch;
        bit  prev  = sclk_o;
        run_i = 1'b1;
        for (int k = 0; k < total; k++) begin
            int    exp = phase_cycles(prev) + ((k == 0) ? 1 : 0);
            int    cyc = 0;
            bit    quiet = 1'b1;
            int    fld = prev ? int'(hi_cnt_i) : int'(lo_cnt_i);
            int    idx = k % (2 * n);
            bit    samp = cpha_i ? idx[0] : !idx[0];
            bit    lastd = cpha_i ? (idx == 2*n - 1) : (idx == 2*n - 2);
            string rq = (fld == 0) ? "R5" : (prev ? "R4" : "R3");
            do begin
                @(negedge clk);
                cyc++;
                if (sclk_o == prev && (sample_o || launch_o || char_done_o)) quiet = 1'b0;
            end while (sclk_o == prev && cyc < 5000);
            if (k == 0) rq = "R10 first edge";
            check(cyc == exp, rq, cyc, exp);
            check(quiet, "R11 strobe without edge", 0, 1);
            check(sample_o == samp, cpha_i ? "R8 sample" : "R7 sample", int'(sample_o), int'(samp));
            check(launch_o == !samp, cpha_i ? "R8 launch" : "R7 launch", int'(launch_o), int'(!samp));
            check(char_done_o == (samp && lastd), "R9 done", int'(char_done_o), int'(samp && lastd));
            if (k == 2 * n * (nch - 1)) run_i = 1'b0;
            prev = sclk_o;
        end
        begin
            bit still = 1'b1;
            repeat (80) begin
                @(negedge clk);
                if (sclk_o != cpol_i || sample_o || launch_o || char_done_o) still = 1'b0;
            end
            check(still, "R10 stop after char (R9 edge count)", 0, 1);
        end
    endtask

    initial begin
        #600000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(sclk_o == 0 && sample_o == 0 && launch_o == 0 && char_done_o == 0, "R1 reset",
              int'({sclk_o, sample_o, launch_o, char_done_o}), 0);
        rst_n = 1'b1;
        // directed corners
        configure(1, 2, 3, 1'b0, 1'b0, 4);  burst(2);   // mode 0
        configure(0, 0, 0, 1'b1, 1'b1, 1);  burst(3);   // mode 3, zero fields, 1 bit
        configure(0, 0, 2, 1'b0, 1'b1, 0);  burst(1);   // mode 1, 16 bits
        configure(3, 7, 2, 1'b1, 1'b0, 3);  burst(2);   // mode 2, larger prescale
        // constrained random
        for (int t = 0; t < 10; t++) begin
            configure(int'($urandom_range(0, 2)), int'($urandom_range(0, 4)),
                      int'($urandom_range(0, 4)), 1'($urandom_range(0, 1)),
                      1'($urandom_range(0, 1)), int'($urandom_range(0, 15)));
            burst(int'($urandom_range(1, 3)));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule